// File: doc/BRIEF.md
# Selectable-Width Down-Counting Interrupt Timer

This block is a cycle-count interrupt timer that sits on a processor write bus. Software builds a 16-bit start value four bits at a time, copies it into a down counter with a separate write, and then arms the timer with a control write. The same control write picks how many low counter bits take part in the expiry test: 4, 8, 12 or 16.

While the timer is armed, the counter steps down by one on each processor-cycle enable pulse. It stops as soon as the watched bits reach zero. On that step it raises a level interrupt request and disarms itself.

The request stays high until software writes either the load address or the control address. The subtraction always covers the full counter, so bits above the watched field survive an expiry. They are used again when a wider field is chosen later. Addresses are decoded with the mask 0xF003, so address bits 11:2 are ignored.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset, irq_o is 0, the start value, counter and armed flag are 0, and the watched width is 16 bits. Enable pulses after reset raise no request, even when the timer is then armed without a load.
- R2: A write to 0xE000, 0xE001, 0xE002 or 0xE003 stores cpu_data[3:0] into start-value bits 3:0, 7:4, 11:8 or 15:12 respectively. Address bits 11:2 are ignored when decoding.
- R3: A write to 0xF000 copies the start value into the counter and drops a pending request in the next cycle.
- R4: A write to 0xF001 sets the armed flag from cpu_data[0] and drops a pending request in the next cycle.
- R5: The 0xF001 write picks the watched mask by priority. cpu_data[3]=1 gives 0x000F; otherwise cpu_data[2]=1 gives 0x00FF; otherwise cpu_data[1]=1 gives 0x0FFF; otherwise the mask is 0xFFFF.
- R6: The counter steps down only on a clock where cpu_tick=1, the timer is armed, and the watched bits are nonzero.
- R7: The step that makes the watched bits zero sets irq_o on that clock edge and disarms the timer.
- R8: While the watched bits are zero, enable pulses neither change the counter nor raise a request.
- R9: irq_o stays 1 until a write to 0xF000 or 0xF001.
- R10: A write to 0xF000 or 0xF001 in the same clock as an enable pulse wins, and that pulse does not step the counter.
- R11: The step is a full 16-bit subtract. Counter bits above the watched field are kept after an expiry and count again once a wider mask is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Write address |
| cpu_data | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one clock per access |
| cpu_tick | input | 1 | Processor-cycle enable |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
The counter is not a port, so a wrong count shows up only as a request that comes too early, too late, or never. A bad nibble or a lost upper bit therefore shifts the expiry by a known number of pulses: 1, 16, 256 or 4096 pulses, depending on which nibble is wrong. A wrong mask or a broken write priority moves the expiry by one pulse or by a whole field. A bench that counts pulses to the exact edge therefore catches each of these faults within one timer run.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int CIT_ADDR_W = 16;
  localparam int CIT_DATA_W = 8;
  localparam int CIT_CNT_W  = 16;
  localparam int CIT_NIB_W  = 4;

  // control-word bit carrying the arm request
  localparam int CIT_ARM_BIT = 0;

  typedef struct packed {
    logic load;   // copy start value into counter
    logic ctrl;   // arm / width write
  } cit_ctl_t;
endpackage

// File: rtl/cit_decode.sv
module cit_decode #(
  parameter int ADDR_W = 16,
  parameter int NIBS = 4,
  parameter logic [ADDR_W-1:0] RLD_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'hF000,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hF003
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NIBS-1:0]   nib_we,
  output cit_pkg::cit_ctl_t ctl
);
  logic [ADDR_W-1:0] a_m;
  assign a_m = addr & DEC_MASK;

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    assign nib_we[k] = wr && (a_m == (RLD_BASE | ADDR_W'(k)));
  end

  assign ctl.load = wr && (a_m == CTL_BASE);
  assign ctl.ctrl = wr && (a_m == (CTL_BASE | ADDR_W'(1)));
endmodule

// File: rtl/cit_reload.sv
module cit_reload #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4,
  localparam int NIBS = CNT_W / NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIBS-1:0]  nib_we,
  input  logic [NIB_W-1:0] nib_data,
  output logic [CNT_W-1:0] reload_q
);
  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst)
        reload_q[k*NIB_W +: NIB_W] <= '0;
      else if (nib_we[k])
        reload_q[k*NIB_W +: NIB_W] <= nib_data;
    end
  end
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4,
  localparam int NIBS = CNT_W / NIB_W,
  localparam int SEL_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             ctrl,
  input  logic [NIBS-1:0]  ctl_data,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_dec, mask;
  logic             en_q, masked_nz, step;
  logic [SEL_W-1:0] wid_q, wid_d;

  // highest set width bit wins; a higher bit means a narrower field
  always_comb begin
    wid_d = SEL_W'(NIBS - 1);
    for (int j = 1; j < NIBS; j++)
      if (ctl_data[j]) wid_d = SEL_W'(NIBS - 1 - j);
  end

  for (genvar k = 0; k < NIBS; k++) begin : g_mask
    assign mask[k*NIB_W +: NIB_W] = {NIB_W{(SEL_W'(k) <= wid_q)}};
  end

  assign masked_nz = |(cnt_q & mask);
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign step      = tick && en_q && !load && !ctrl && masked_nz;
  assign fire      = step && ~|(cnt_dec & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      wid_q <= SEL_W'(NIBS - 1);
    end else begin
      if (load)      cnt_q <= reload;
      else if (step) cnt_q <= cnt_dec;
      if (ctrl) begin
        en_q  <= ctl_data[cit_pkg::CIT_ARM_BIT];
        wid_q <= wid_d;
      end else if (fire) begin
        en_q <= 1'b0;
      end
    end
  end

  // R7: an expiry disarms the timer
  a_r7_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    fire |=> !en_q);
  // R10: a load write beats a same-cycle pulse
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load && tick) |=> (cnt_q == $past(reload)));
  // R6: no pulse, no load -> counter holds
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  // R8: watched bits at zero -> counter holds and no expiry
  a_r8_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (!masked_nz && !load) |=> $stable(cnt_q));
  a_r8_zero_no_fire: assert property (@(posedge clk) disable iff (rst)
    !masked_nz |-> !fire);
endmodule

// File: rtl/cit_irq_flag.sv
module cit_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)      irq_q <= 1'b0;
    else if (clr) irq_q <= 1'b0;
    else if (set) irq_q <= 1'b1;
  end

  // R9: request holds until acknowledged
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr) |=> irq_q);
  // R3 / R4: acknowledge drops the request
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq_q);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int ADDR_W = cit_pkg::CIT_ADDR_W,
  parameter int DATA_W = cit_pkg::CIT_DATA_W,
  parameter int CNT_W  = cit_pkg::CIT_CNT_W,
  parameter int NIB_W  = cit_pkg::CIT_NIB_W,
  parameter logic [ADDR_W-1:0] RLD_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'hF000,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hF003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  input  logic              cpu_tick,
  output logic              irq_o
);
  localparam int NIBS = CNT_W / NIB_W;

  logic [NIBS-1:0]   nib_we;
  cit_pkg::cit_ctl_t ctl;
  logic [CNT_W-1:0]  reload_q;
  logic              fire;
  logic              unused_data;

  assign unused_data = ^cpu_data[DATA_W-1:NIB_W];

  cit_decode #(.ADDR_W(ADDR_W), .NIBS(NIBS), .RLD_BASE(RLD_BASE),
               .CTL_BASE(CTL_BASE), .DEC_MASK(DEC_MASK)) u_dec (
    .addr(cpu_addr), .wr(cpu_wr), .nib_we(nib_we), .ctl(ctl));

  cit_reload #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_rld (
    .clk(clk), .rst(rst), .nib_we(nib_we),
    .nib_data(cpu_data[NIB_W-1:0]), .reload_q(reload_q));

  cit_counter #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_cnt (
    .clk(clk), .rst(rst), .load(ctl.load), .ctrl(ctl.ctrl),
    .ctl_data(cpu_data[NIBS-1:0]), .tick(cpu_tick), .reload(reload_q),
    .fire(fire));

  cit_irq_flag u_irq (
    .clk(clk), .rst(rst), .set(fire), .clr(ctl.load || ctl.ctrl),
    .irq_q(irq_o));
endmodule

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic cpu_wr = 1'b0, cpu_tick = 1'b0;
  logic irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  logic [15:0] m_rld, m_cnt, m_mask;
  logic m_en, m_irq;

  always #10 clk = ~clk;

  cyc_irq_timer dut_i (.clk(clk), .rst(rst), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_wr(cpu_wr), .cpu_tick(cpu_tick), .irq_o(irq_o));

  function automatic logic [15:0] mask_for(input logic [7:0] d);
    if (d[3])      return 16'h000F;
    else if (d[2]) return 16'h00FF;
    else if (d[1]) return 16'h0FFF;
    else           return 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    logic [15:0] a;
    logic [15:0] dec;
    a = cpu_addr & 16'hF003;
    if (rst) begin
      m_rld = '0; m_cnt = '0; m_mask = 16'hFFFF; m_en = 0; m_irq = 0;
    end else if (cpu_wr && a == 16'hF000) begin
      m_cnt = m_rld; m_irq = 0;
    end else if (cpu_wr && a == 16'hF001) begin
      m_en = cpu_data[0]; m_mask = mask_for(cpu_data); m_irq = 0;
    end else begin
      if (cpu_wr && a[15:2] == 14'h3800)
        m_rld[a[1:0]*4 +: 4] = cpu_data[3:0];
      if (cpu_tick && m_en && (m_cnt & m_mask) != 0) begin
        dec = m_cnt - 16'd1;
        m_cnt = dec;
        if ((dec & m_mask) == 0) begin m_irq = 1; m_en = 0; end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_tick = tk;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cpu_tick = 1'b1;
    end
    @(negedge clk); cpu_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_reload(input logic [15:0] v);
    for (int k = 0; k < 4; k++) wr(16'hE000 | 16'(k), {4'h0, v[k*4 +: 4]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset level", irq_o, 1'b0);
    wr(16'hF001, 8'h01);                 // arm with counter at 0
    ticks(5);
    chk("R1 no expiry from reset count", irq_o, 1'b0);
    chk("R8 zero count raises nothing", irq_o, 1'b0);

    // basic 16-bit run: 3 pulses
    set_reload(16'h0003);
    wr(16'hF000, 8'h00);
    wr(16'hF001, 8'h01);
    ticks(2);
    chk("R6 before expiry", irq_o, 1'b0);
    ticks(1);
    chk("R7 expiry on third pulse", irq_o, 1'b1);
    ticks(4);
    chk("R9 request holds", irq_o, 1'b1);
    idle(3);
    chk("R9 request holds idle", irq_o, 1'b1);
    wr(16'hF001, 8'h00);
    chk("R4 control write acknowledges", irq_o, 1'b0);

    // R8: re-arm with watched bits zero
    wr(16'hF001, 8'h01);
    ticks(20);
    chk("R8 no second expiry", irq_o, 1'b0);

    // nibble positions and width priority with aliased addresses
    wr(16'hE00C, 8'hF1);                 // nibble 0 via alias = 1
    wr(16'hE001, 8'h03);
    wr(16'hE3F2, 8'h02);                 // alias of E002
    wr(16'hE003, 8'h01);                 // start = 0x1231
    wr(16'hF000, 8'h00);
    wr(16'hF001, 8'h0F);                 // bit3 wins -> 4-bit field
    idle(4);
    chk("R6 no pulses no step", irq_o, 1'b0);
    ticks(1);
    chk("R2/R5 4-bit expiry after 1 pulse", irq_o, 1'b1);
    wr(16'hF001, 8'h07);                 // bit2 wins -> 8-bit, counter 0x1230
    chk("R4 ack", irq_o, 1'b0);
    ticks(47);
    chk("R11 8-bit not yet", irq_o, 1'b0);
    ticks(1);
    chk("R11 8-bit expiry after 48", irq_o, 1'b1);
    wr(16'hF001, 8'h03);                 // 12-bit, counter 0x1200
    ticks(511);
    chk("R11 12-bit not yet", irq_o, 1'b0);
    ticks(1);
    chk("R2 12-bit expiry after 512", irq_o, 1'b1);
    wr(16'hF001, 8'h01);                 // 16-bit, counter 0x1000
    ticks(4095);
    chk("R11 16-bit not yet", irq_o, 1'b0);
    ticks(1);
    chk("R2 16-bit expiry after 4096", irq_o, 1'b1);
    wr(16'hF000, 8'h00);
    chk("R3 load write acknowledges", irq_o, 1'b0);

    // R10: writes with a same-cycle pulse
    set_reload(16'h0005);
    wr(16'hF001, 8'h01);
    wr(16'hF000, 8'h00, 1'b1);           // load with pulse: counter stays 5
    ticks(4);
    chk("R10 load beats pulse (4)", irq_o, 1'b0);
    ticks(1);
    chk("R10 load beats pulse (5)", irq_o, 1'b1);
    set_reload(16'h0001);
    wr(16'hF000, 8'h00);
    wr(16'hF001, 8'h01, 1'b1);           // arm with pulse: no step
    chk("R10 control beats pulse", irq_o, 1'b0);
    ticks(1);
    chk("R10 next pulse expires", irq_o, 1'b1);
    wr(16'hF002, 8'h03);                 // unrelated address
    chk("R9 other address no ack", irq_o, 1'b1);

    // constrained random against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      @(negedge clk);
      chk("R6/R7 random vs model", irq_o, m_irq);
      r = $urandom;
      cpu_tick = (r[3:0] < 4'd11);
      cpu_wr = (r[7:4] < 4'd3);
      case (r[10:8])
        3'd0, 3'd1: cpu_addr = 16'hE000 | (16'(r[31:20]) & 16'h0FFC) | 16'(r[12:11]);
        3'd2:       cpu_addr = 16'hF000;
        3'd3, 3'd4: cpu_addr = 16'hF001 | (16'(r[31:20]) & 16'h0FFC);
        3'd5:       cpu_addr = 16'hF002;
        default:    cpu_addr = 16'h8000 | 16'(r[31:20]);
      endcase
      cpu_data = {r[19:16], r[15:14] == 2'b00 ? r[13] : 1'b0, r[15:13] != 3'b0 ? 2'b01 : 2'b00, 1'b1};
      if (cpu_addr[15:12] == 4'hE) cpu_data = {4'h0, 2'b00, r[14:13]};
    end
    @(negedge clk);
    cpu_wr = 1'b0; cpu_tick = 1'b0;
    chk("R7 random final vs model", irq_o, m_irq);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule